// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block is a 1 KB direct-mapped cache between a 32-bit requester and a word-wide memory port. Each address is split into three fields: a byte offset, a line index and a tag. Every line holds one valid flag, one tag and eight data words. The requester places an access on its port and keeps it there until `cpu_ready` pulses. A read that finds its line completes in the same cycle and does not use memory.

When the line is missing, the cache holds the requester off. It then reads the eight words of the line from memory in ascending order, installs the line, and restarts the access, which now hits. Writes always reach memory as a single word write. A write that misses first brings the line in, then merges the word and writes it through. `cpu_hit` qualifies each completion and tells whether a fill was needed.

Top module: `dm_wt_cache`

## Requirements
- R1: Address bits [4:0] are the byte offset within a 32-byte line. Bits [9:5] select one of 32 lines. Bits [31:10] are the stored tag. Addresses that differ only in bits [4:0] share a line, and a change in bits [9:5] selects another line.
- R2: An access hits when the indexed line is valid and its stored tag equals the address tag. `cpu_hit` is 1 with `cpu_ready` exactly when the access completed without a fill.
- R3: Reset clears every valid flag. While reset is held and right after it ends, `cpu_ready` and `mem_req` are 0. The first access to any line after reset misses.
- R4: On a read miss, `cpu_ready` stays 0 while exactly 8 memory reads fill the line. The access then completes with the word held in memory and `cpu_hit` = 0.
- R5: The fill reads go to addresses {tag, index, k, 2'b00} for k = 0 to 7 in that order. `mem_req`, `mem_we` and `mem_addr` are held until `mem_ack`.
- R6: A write hit updates the cached word and issues exactly one memory write of `cpu_wdata` at {cpu_addr[31:2], 2'b00}, with no memory reads. It completes on that write's `mem_ack`, with `cpu_hit` = 1.
- R7: A read hit asserts `cpu_ready` in the cycle the request is presented, issues no memory access, and returns the most recent data for that word.
- R8: A write miss first fills the line with 8 reads, then performs one write-through. It completes with `cpu_hit` = 0. Later reads of the other words of that line hit and return memory data.
- R9: A fill into an index held by another tag replaces that line, so the evicted address misses on its next access. The requester holds `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` stable until `cpu_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = word write, 0 = word read |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` on reads |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Completion needed no fill |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory accepts or returns one word |

## Verification
The assertions check these rules on every cycle: the memory handshake is held until `mem_ack`, fill addresses advance one word per acknowledged read, a read hit stays off the memory port, a miss stalls the requester and starts a read, and a write hit is followed by a write-through. A completed fill must also leave its line valid. Other behaviour shows only across whole access sequences in the scenarios: returned data matching memory, the eviction of a conflicting tag, a written word surviving an eviction, and reset dropping all lines. The scenarios vary the memory latency so that both the back-to-back and the waiting handshakes are covered.

// File: rtl/dm_wt_cache.sv
module dm_wt_cache #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              cpu_hit,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int WPL    = LINE_BYTES / (DATA_W / 8);
  localparam int WSEL_W = OFF_W - BYTE_W;
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_WRITE} st_t;

  st_t                state_q;
  logic [NUM_LINES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q  [NUM_LINES];
  logic [DATA_W-1:0]  data_q [NUM_LINES*WPL];
  logic [WSEL_W-1:0]  cnt_q;
  logic               miss_q;

  wire [IDX_W-1:0]  idx  = cpu_addr[OFF_W+IDX_W-1:OFF_W];
  wire [TAG_W-1:0]  tag  = cpu_addr[ADDR_W-1:OFF_W+IDX_W];
  wire [WSEL_W-1:0] wsel = cpu_addr[OFF_W-1:BYTE_W];
  wire unused_low = &{1'b0, cpu_addr[BYTE_W-1:0]};

  wire hit       = valid_q[idx] && (tag_q[idx] == tag);
  wire lookup    = (state_q == S_IDLE) && cpu_req;
  wire fill_last = (state_q == S_FILL) && mem_ack && (cnt_q == WSEL_W'(WPL-1));

  assign cpu_ready = (lookup && hit && !cpu_we) || ((state_q == S_WRITE) && mem_ack);
  assign cpu_hit   = cpu_ready && !miss_q;
  assign cpu_rdata = data_q[{idx, wsel}];
  assign mem_req   = (state_q != S_IDLE);
  assign mem_we    = (state_q == S_WRITE);
  assign mem_wdata = cpu_wdata;
  assign mem_addr  = (state_q == S_FILL) ? {tag, idx, cnt_q, {BYTE_W{1'b0}}}
                                         : {cpu_addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      valid_q <= '0;
      cnt_q   <= '0;
      miss_q  <= 1'b0;
    end else begin
      if (lookup && !hit) miss_q <= 1'b1;
      else if (cpu_ready) miss_q <= 1'b0;
      case (state_q)
        S_IDLE: if (lookup) begin
          if (!hit) begin
            state_q <= S_FILL;
            cnt_q   <= '0;
          end else if (cpu_we) begin
            state_q <= S_WRITE;
          end
        end
        S_FILL: if (mem_ack) begin
          cnt_q <= cnt_q + 1'b1;
          if (fill_last) begin
            valid_q[idx] <= 1'b1;
            state_q      <= S_IDLE;
          end
        end
        S_WRITE: if (mem_ack) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (fill_last) tag_q[idx] <= tag;
    if ((state_q == S_FILL) && mem_ack) data_q[{idx, cnt_q}] <= mem_rdata;
    else if (lookup && hit && cpu_we) data_q[{idx, wsel}] <= cpu_wdata;
  end

  AST_RESET_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (valid_q == '0)); // R3
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_FILL) && mem_ack && !fill_last) |=>
      (mem_req && !mem_we && mem_addr[OFF_W-1:BYTE_W] == $past(mem_addr[OFF_W-1:BYTE_W]) + 1'b1)); // R5
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R5
  AST_MISS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup && !hit) |-> (!cpu_ready ##1 (mem_req && !mem_we && !cpu_ready))); // R4
  AST_READ_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup && hit && !cpu_we) |-> (cpu_ready && !mem_req)); // R7
  AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup && hit && cpu_we) |=> (mem_req && mem_we)); // R6
  AST_FILL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fill_last |=> valid_q[$past(idx)]); // R2
endmodule

// File: tb/dm_wt_cache_tb_top.sv
module dm_wt_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        cpu_ready, cpu_hit, mem_req, mem_we;
  logic        mem_ack = 1'b0;

  always #10 clk = ~clk;

  dm_wt_cache dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  logic [31:0] mem_model [4096];
  logic [31:0] ref_mem   [4096];
  int lat = 0, wait_c = 0;
  int rd_cnt = 0, wr_cnt = 0;
  bit seq_err = 0, wt_err = 0;
  int n_chk = 0, n_bad = 0, cyc = 0;

  localparam logic [31:0] DA = 32'hA1B2C3D4, DB = 32'h0BADF00D, DC = 32'hCAFE1234;
  // {we, expected hit, address, write data}
  localparam logic [65:0] VEC [14] = '{
    {1'b0, 1'b0, 32'h0000_0040, 32'h0},
    {1'b0, 1'b1, 32'h0000_005C, 32'h0},
    {1'b0, 1'b0, 32'h0000_0440, 32'h0},
    {1'b0, 1'b0, 32'h0000_0040, 32'h0},
    {1'b1, 1'b1, 32'h0000_0048, DA},
    {1'b0, 1'b1, 32'h0000_0048, 32'h0},
    {1'b1, 1'b0, 32'h0000_0864, DB},
    {1'b0, 1'b1, 32'h0000_0860, 32'h0},
    {1'b0, 1'b1, 32'h0000_0864, 32'h0},
    {1'b0, 1'b0, 32'h0000_3FFC, 32'h0},
    {1'b0, 1'b1, 32'h0000_3FE0, 32'h0},
    {1'b1, 1'b1, 32'h0000_0048, DC},
    {1'b0, 1'b0, 32'h0000_0448, 32'h0},
    {1'b0, 1'b0, 32'h0000_0048, 32'h0}
  };

  initial begin
    for (int i = 0; i < 4096; i++) begin
      mem_model[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
      ref_mem[i]   = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
    end
  end

  always @(negedge clk) begin
    if (mem_req) begin
      if (wait_c >= lat) begin
        mem_ack   = 1'b1;
        mem_rdata = mem_model[mem_addr[13:2]];
        wait_c    = 0;
      end else begin
        mem_ack = 1'b0;
        wait_c++;
      end
    end else begin
      mem_ack = 1'b0;
      wait_c  = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        if (mem_addr != {cpu_addr[31:2], 2'b00} || mem_wdata != cpu_wdata) wt_err = 1;
        mem_model[mem_addr[13:2]] = mem_wdata;
        wr_cnt++;
      end else begin
        if (mem_addr[4:2] != rd_cnt[2:0] || mem_addr[31:5] != cpu_addr[31:5]
            || mem_addr[1:0] != 2'b00) seq_err = 1;
        rd_cnt++;
      end
    end
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: run hung, act cycles=%0d exp <=100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic hit, output int nrd, output int nwr);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    rd_cnt = 0; wr_cnt = 0; seq_err = 0; wt_err = 0;
    #2;
    while (!cpu_ready) begin
      @(negedge clk);
      #2;
    end
    rd  = cpu_rdata;
    hit = cpu_hit;
    @(posedge clk);
    #1;
    nrd = rd_cnt; nwr = wr_cnt;
    cpu_req = 1'b0;
    if (we) ref_mem[a[13:2]] = d;
  endtask

  task automatic run_one(input logic we, input logic exp_hit, input logic [31:0] a,
                         input logic [31:0] d, input string tagstr);
    logic [31:0] rd;
    logic hit;
    int nrd, nwr;
    access(we, a, d, rd, hit, nrd, nwr);
    chk(hit == exp_hit, {tagstr, " hit flag"}, 32'(hit), 32'(exp_hit));
    chk(nrd == (exp_hit ? 0 : 8), {tagstr, " fill read count"}, nrd, exp_hit ? 0 : 8);
    chk(!seq_err, "R5 fill address order", 32'(seq_err), 0);
    chk(nwr == 32'(we), "R6 write-through count", nwr, 32'(we));
    if (we) chk(!wt_err, "R6 write-through address/data", 32'(wt_err), 0);
    else chk(rd == ref_mem[a[13:2]], {tagstr, " read data"}, rd, ref_mem[a[13:2]]);
  endtask

  function automatic string tag_of(input logic we, input logic h);
    if (we) return h ? "R6" : "R8";
    return h ? "R7" : "R4";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(!cpu_ready && !mem_req, "R3 outputs idle in reset", {cpu_ready, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cpu_ready && !mem_req, "R3 outputs idle after reset", {cpu_ready, mem_req}, 0);

    // table walk: R2 hit flags, R9 evictions at entries 2,3,12,13
    for (int i = 0; i < 14; i++) begin
      lat = i % 3;
      run_one(VEC[i][65], VEC[i][64], VEC[i][63:32], VEC[i][31:0], tag_of(VEC[i][65], VEC[i][64]));
    end
    // written word must sit in memory after eviction (R6, R9)
    chk(mem_model[12'h012] == DC, "R9 evicted write kept in memory", mem_model[12'h012], DC);
    chk(mem_model[12'h219] == DB, "R8 write-miss data in memory", mem_model[12'h219], DB);

    // R1 field split
    lat = 1;
    run_one(1'b0, 1'b0, 32'h0000_07C0, 32'h0, "R1 new line");
    run_one(1'b0, 1'b1, 32'h0000_07DC, 32'h0, "R1 same line offset");
    run_one(1'b0, 1'b0, 32'h0000_07E0, 32'h0, "R1 next index");
    run_one(1'b0, 1'b0, 32'h0000_03C0, 32'h0, "R1 same index other tag");

    // R3 reset drops all lines
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    lat = 0;
    run_one(1'b0, 1'b0, 32'h0000_0048, 32'h0, "R3 miss after reset");
    run_one(1'b0, 1'b1, 32'h0000_0048, 32'h0, "R2 refilled line");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule